// File: doc/BRIEF.md
# Asymmetric Directory-Set Way Selector

This block picks ways inside one 16-way set of a region-tracking coherence directory. In that set, twelve ways (0 to 11) hold full-region entries with a slot for every block of the region. Four ways (12 to 15) are narrow entries that can track only one block. A single binary-tree pseudo-LRU covers all sixteen ways. It serves two jobs: choosing a victim when a new region arrives, and choosing a destination when an entry must leave a narrow way.

Requests arrive as a single-cycle strobe with an operation code. A touch records a hit. A new-region miss asks for a victim from the whole set. A promotion is issued when a region held in a narrow way gains a second cached block. For a promotion, the selector prefers a vacant full way. Failing that, it prefers a full way whose entry covers only one block, so the two entries can trade places. As a last resort it evicts a full way found by a tree walk that never enters the narrow ways.

The block always accepts a request and applies no back-pressure. Its result is a registered pulse that appears one cycle after the request. Tag storage, entry contents and the actual move, swap or invalidation belong to the surrounding logic.

Top module: `asel_set_selector`

## Requirements
- R1: A request with `req_op` 1 (miss) or 2 (promote) produces `rsp_valid` high for exactly the next cycle. `req_op` 0 (touch) and 3 (reserved) produce no response, and so does an idle cycle.
- R2: While `rst_n` is low, `rsp_valid` is low. After reset every tree bit is 0, so the first new-region miss names way 0.
- R3: A new-region miss walks the full tree and may name any way, narrow ways included. It returns case code 3 (`rsp_case`=2'b11), and `rsp_evict` equals `way_valid` of the named way.
- R4: Tree encoding: node bit 0 steers the walk to the lower-numbered half, and 1 steers it to the upper half. A touch, a miss fill or a promotion target sets every node on that way's path to point away from it. From reset, back-to-back misses therefore name ways 0, 8, 4, 12.
- R5: Promotion case 0 (2'b00): if any full way (0 to 11) is invalid, the lowest such way is returned with `rsp_evict`=0.
- R6: Promotion case 1 (2'b01): if all full ways are valid and one or more have `full_one` set, the lowest such way is returned with `rsp_evict`=0.
- R7: Promotion case 2 (2'b10): if all full ways are valid and none has `full_one` set, the way is found by a tree walk that turns away from any subtree that contains no full way. `rsp_evict`=1, and the returned way is never 12 to 15.
- R8: The way returned by a promotion is recorded in the tree as recently used.
- R9: The valid bits of narrow ways have no effect on a promotion. A vacant narrow way is never returned as a promotion target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 0 touch, 1 new-region miss, 2 promote, 3 reserved |
| req_way | input | 4 | Way that was hit (touch only) |
| way_valid | input | 16 | Per-way entry valid |
| full_one | input | 12 | Per full way: entry covers only one block |
| rsp_valid | output | 1 | Result strobe, one cycle after a miss or promote |
| rsp_case | output | 2 | 0 move, 1 swap, 2 evict-and-move, 3 new-region victim |
| rsp_way | output | 4 | Victim or destination way |
| rsp_evict | output | 1 | Surrounding logic must invalidate the region in `rsp_way` |

## Verification
Runs of consecutive misses from reset check that the tree visits the expected order and that a narrow way can be a victim. A matching run of touches then shows that hits steer the tree in the same way that fills do. Promotions are issued under three occupancy patterns: a vacant full way, only single-block full entries, and every full way multi-block. Each pattern isolates one priority case, and the ordering of the ways present shows the lowest-index tie-break. The evict-and-move case is tried in a tree state where the unconstrained walk would land on a narrow way, so the constrained walk must take a different path. A pattern with vacant, flagged narrow ways shows that those ways are ignored. A miss issued after a move confirms that the promotion target was recorded as recently used.

// File: rtl/asel_pkg.sv
package asel_pkg;
  typedef enum logic [1:0] {
    OP_TOUCH = 2'd0,
    OP_MISS  = 2'd1,
    OP_PROMO = 2'd2,
    OP_RSVD  = 2'd3
  } asel_op_e;

  typedef enum logic [1:0] {
    CS_MOVE  = 2'd0,
    CS_SWAP  = 2'd1,
    CS_EVICT = 2'd2,
    CS_NEWV  = 2'd3
  } asel_case_e;
endpackage

// File: rtl/asel_plru.sv
module asel_plru #(
  parameter int NUM_WAYS = 16,
  parameter int NUM_FULL = 12,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  output logic [WAY_W-1:0] vict_any,
  output logic [WAY_W-1:0] vict_full
);
  // heap-indexed tree: node n has children 2n and 2n+1
  logic [NUM_WAYS-1:1] tree_q, tree_d;

  function automatic logic [WAY_W-1:0] walk(input logic [NUM_WAYS-1:1] t,
                                            input logic only_full);
    logic [WAY_W-1:0] node, pfx;
    logic d;
    node = WAY_W'(1);
    pfx  = '0;
    for (int l = 0; l < WAY_W; l++) begin
      d = t[node];
      // lowest way of the chosen subtree decides whether it holds a full way
      if (only_full && ((int'({pfx[WAY_W-2:0], d}) << (WAY_W-1-l)) >= NUM_FULL))
        d = ~d;
      pfx  = {pfx[WAY_W-2:0], d};
      node = {node[WAY_W-2:0], d};
    end
    return pfx;
  endfunction

  assign vict_any  = walk(tree_q, 1'b0);
  assign vict_full = walk(tree_q, 1'b1);

  always_comb begin
    logic [WAY_W-1:0] node;
    logic b;
    tree_d = tree_q;
    node   = WAY_W'(1);
    for (int l = 0; l < WAY_W; l++) begin
      b            = upd_way[WAY_W-1-l];
      tree_d[node] = ~b;
      node         = {node[WAY_W-2:0], b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tree_q <= '0;
    else if (upd_en) tree_q <= tree_d;
  end
endmodule

// File: rtl/asel_promo_pick.sv
module asel_promo_pick #(
  parameter int NUM_WAYS = 16,
  parameter int NUM_FULL = 12,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_FULL-1:0] full_valid,
  input  logic [NUM_FULL-1:0] full_one,
  output logic                vac_hit,
  output logic [WAY_W-1:0]    vac_way,
  output logic                one_hit,
  output logic [WAY_W-1:0]    one_way
);
  // scan downward so the lowest qualifying way is the last one written
  always_comb begin
    vac_hit = 1'b0;
    vac_way = '0;
    one_hit = 1'b0;
    one_way = '0;
    for (int w = NUM_FULL-1; w >= 0; w--) begin
      if (!full_valid[w]) begin
        vac_hit = 1'b1;
        vac_way = WAY_W'(w);
      end
      if (full_valid[w] && full_one[w]) begin
        one_hit = 1'b1;
        one_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/asel_set_selector.sv
module asel_set_selector
  import asel_pkg::*;
#(
  parameter int NUM_WAYS   = 16,
  parameter int NUM_SINGLE = 4,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int NUM_FULL  = NUM_WAYS - NUM_SINGLE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [WAY_W-1:0]    req_way,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [NUM_FULL-1:0] full_one,
  output logic                rsp_valid,
  output logic [1:0]          rsp_case,
  output logic [WAY_W-1:0]    rsp_way,
  output logic                rsp_evict
);
  logic             upd_en;
  logic [WAY_W-1:0] upd_way;
  logic [WAY_W-1:0] vict_any, vict_full;
  logic             vac_hit, one_hit;
  logic [WAY_W-1:0] vac_way, one_way;
  logic             nxt_valid, nxt_evict;
  asel_case_e       nxt_case;
  logic [WAY_W-1:0] nxt_way;

  asel_plru #(.NUM_WAYS(NUM_WAYS), .NUM_FULL(NUM_FULL)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_way  (upd_way),
    .vict_any (vict_any),
    .vict_full(vict_full)
  );

  asel_promo_pick #(.NUM_WAYS(NUM_WAYS), .NUM_FULL(NUM_FULL)) u_pick (
    .full_valid(way_valid[NUM_FULL-1:0]),
    .full_one  (full_one),
    .vac_hit   (vac_hit),
    .vac_way   (vac_way),
    .one_hit   (one_hit),
    .one_way   (one_way)
  );

  always_comb begin
    upd_en    = 1'b0;
    upd_way   = req_way;
    nxt_valid = 1'b0;
    nxt_case  = CS_NEWV;
    nxt_way   = '0;
    nxt_evict = 1'b0;
    if (req_valid) begin
      unique case (asel_op_e'(req_op))
        OP_TOUCH: upd_en = 1'b1;
        OP_MISS: begin
          nxt_valid = 1'b1;
          nxt_case  = CS_NEWV;
          nxt_way   = vict_any;
          nxt_evict = way_valid[vict_any];
          upd_en    = 1'b1;
          upd_way   = vict_any;
        end
        OP_PROMO: begin
          nxt_valid = 1'b1;
          if (vac_hit) begin
            nxt_case = CS_MOVE;
            nxt_way  = vac_way;
          end else if (one_hit) begin
            nxt_case = CS_SWAP;
            nxt_way  = one_way;
          end else begin
            nxt_case  = CS_EVICT;
            nxt_way   = vict_full;
            nxt_evict = 1'b1;
          end
          upd_en  = 1'b1;
          upd_way = nxt_way;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_case  <= 2'b00;
      rsp_way   <= '0;
      rsp_evict <= 1'b0;
    end else begin
      rsp_valid <= nxt_valid;
      if (nxt_valid) begin
        rsp_case  <= nxt_case;
        rsp_way   <= nxt_way;
        rsp_evict <= nxt_evict;
      end
    end
  end
endmodule

// File: rtl/asel_checks.sv
module asel_checks #(
  parameter int NUM_WAYS   = 16,
  parameter int NUM_SINGLE = 4,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int NUM_FULL  = NUM_WAYS - NUM_SINGLE
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic [WAY_W-1:0]    req_way,
  input logic [NUM_WAYS-1:0] way_valid,
  input logic [NUM_FULL-1:0] full_one,
  input logic                rsp_valid,
  input logic [1:0]          rsp_case,
  input logic [WAY_W-1:0]    rsp_way,
  input logic                rsp_evict
);
  logic [NUM_WAYS-1:0] valid_prev;
  logic                answers;
  logic                full_has_vacancy;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_prev <= '0;
    else        valid_prev <= way_valid;
  end

  assign answers          = req_valid && (req_op == 2'd1 || req_op == 2'd2);
  assign full_has_vacancy = !(&way_valid[NUM_FULL-1:0]);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    answers |=> rsp_valid);  // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !answers |=> !rsp_valid);  // R1
  AST_MISS_EVICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |=> (rsp_case == 2'd3 && rsp_evict == valid_prev[rsp_way]));  // R3
  AST_TOUCH_STEERS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) ##1 (req_valid && req_op == 2'd1)
      |=> rsp_way != $past(req_way, 2));  // R4
  AST_VACANT_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && full_has_vacancy)
      |=> (rsp_case == 2'd0 && !rsp_evict && !valid_prev[rsp_way]));  // R5
  AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_case == 2'd1) |-> !rsp_evict);  // R6
  AST_PROMO_TARGET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_case != 2'd3) |-> (int'(rsp_way) < NUM_FULL));  // R7
  AST_EVICT_CASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_case == 2'd2) |-> rsp_evict);  // R7
endmodule

bind asel_set_selector asel_checks #(.NUM_WAYS(NUM_WAYS), .NUM_SINGLE(NUM_SINGLE)) u_chk (.*);

// File: tb/sim_asel_set_selector.sv
module sim_asel_set_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [3:0]  req_way = 4'd0;
  logic [15:0] way_valid = '0;
  logic [11:0] full_one = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_case;
  logic [3:0]  rsp_way;
  logic        rsp_evict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] cs;
    logic [3:0] way;
    logic       ev;
    string      rq;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  asel_set_selector u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_way(req_way), .way_valid(way_valid), .full_one(full_one),
    .rsp_valid(rsp_valid), .rsp_case(rsp_case), .rsp_way(rsp_way),
    .rsp_evict(rsp_evict)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response case=%0d way=%0d expected none",
                 rsp_case, rsp_way);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_case !== e.cs || rsp_way !== e.way || rsp_evict !== e.ev) begin
          errors++;
          $display("FAIL %s case/way/evict actual %0d/%0d/%0d expected %0d/%0d/%0d",
                   e.rq, rsp_case, rsp_way, rsp_evict, e.cs, e.way, e.ev);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 rsp_valid in reset actual %0b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] w,
                       input logic [15:0] v, input logic [11:0] one);
    req_valid = 1'b1;
    req_op    = op;
    req_way   = w;
    way_valid = v;
    full_one  = one;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_req(input logic [1:0] op, input logic [15:0] v,
                            input logic [11:0] one, input logic [1:0] cs,
                            input logic [3:0] way, input logic ev, input string rq);
    exp_t e;
    e.cs = cs; e.way = way; e.ev = ev; e.rq = rq;
    q.push_back(e);
    issue(op, 4'd0, v, one);
  endtask

  task automatic check_quiet(input string rq);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s rsp_valid actual %0b expected 0", rq, rsp_valid);
    end
  endtask

  initial begin
    do_reset();
    // R2 / R3: first miss from reset, empty set
    expect_req(2'd1, 16'h0000, 12'h000, 2'd3, 4'd0, 1'b0, "R2");
    // R3 / R4: miss order 8, 4, 12 with full occupancy
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd8, 1'b1, "R4");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd4, 1'b1, "R4");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd12, 1'b1, "R3");
    @(negedge clk);

    // R4 / R1: touches steer the tree and give no response
    do_reset();
    issue(2'd0, 4'd0, 16'hFFFF, 12'h000);
    check_quiet("R1");
    issue(2'd0, 4'd8, 16'hFFFF, 12'h000);
    check_quiet("R1");
    issue(2'd3, 4'd4, 16'hFFFF, 12'h000);
    check_quiet("R1");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd4, 1'b1, "R4");
    @(negedge clk);

    // R5 / R8: vacant full ways 5 and 9, lowest chosen, then target recorded
    do_reset();
    expect_req(2'd2, 16'hFDDF, 12'hFFF, 2'd0, 4'd5, 1'b0, "R5");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd8, 1'b1, "R8");
    // R6: single-block full entries at 3 and 7
    expect_req(2'd2, 16'hFFFF, 12'h088, 2'd1, 4'd3, 1'b0, "R6");
    @(negedge clk);

    // R9: narrow ways vacant, all full ways busy and multi-block
    do_reset();
    expect_req(2'd2, 16'h0FFF, 12'h000, 2'd2, 4'd0, 1'b1, "R9");
    @(negedge clk);

    // R7: tree pointing at narrow way 12, constrained walk lands on 10
    do_reset();
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd0, 1'b1, "R4");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd8, 1'b1, "R4");
    expect_req(2'd1, 16'hFFFF, 12'h000, 2'd3, 4'd4, 1'b1, "R4");
    expect_req(2'd2, 16'hFFFF, 12'h000, 2'd2, 4'd10, 1'b1, "R7");
    @(negedge clk);
    @(negedge clk);
    check_quiet("R1");

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses actual %0d expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule